// File: doc/BRIEF.md
# Call and Loop Context Stack

This block follows a processor's retired control flow and keeps a shallow hardware stack of the function calls and loops that are currently active. Each event arrives already classified as a call, a return or a taken branch, and carries its own PC and its destination. Calls push a function entry. Returns unwind to the caller. A branch that jumps backwards is treated as the closing branch of a loop, so it opens a loop entry. A branch that leaves the range of the loop on top closes that loop.

A phase tracker divides execution into intervals using two strobes. At the start strobe, every entry already on the stack is marked stable. An entry pushed later in the interval begins unstable, and an entry that is popped loses its mark. At the end strobe, the block takes the unbroken run of stable entries counted from the bottom of the stack. One cycle later it reports the size of that run and a 32-bit fold of the run's addresses. Downstream logic uses this as a code-region signature.

Recursion and overflow put the block into a hold mode, so the stack does not fill up with repeated frames. Recursion means a call to a function that is already on the stack. Overflow means a push when the stack is full. In hold mode the block waits until a return lands just after a call site that it still holds, and then resumes normal operation.

Top module: `ctx_stack_tracker`

## Requirements
- R1: After reset the depth is 0, hold mode is off, the error flag is 0 and sig_valid is 0. ev_ready is always 1, and an event with ev_valid low or ev_kind 2'b00 changes nothing.
- R2: A call has ev_kind 2'b01. Outside hold mode, a call whose destination is not the callee of any stored function entry pushes a function entry that holds (call PC, callee address), and the depth grows by one.
- R3: A return has ev_kind 2'b10. Outside hold mode, a return removes the topmost function entry together with every loop entry above it.
- R4: A taken branch has ev_kind 2'b11. It is backward when its target is less than its PC, and a backward branch pushes a loop entry (start = target, end = PC). If the top entry is a loop with the same start and end, the branch is a further iteration and the stack is left unchanged.
- R5: A branch whose target is below the start or above the end of the loop entry on top pops that loop. If the same branch is also backward, the new loop entry takes the freed slot.
- R6: A return that finds no function entry on the stack empties the stack and sets a sticky error flag, which only reset clears.
- R7: A call whose destination equals the callee of a stored function entry pushes nothing and enters hold mode. The lowest such entry becomes the boundary.
- R8: Any push attempted while DEPTH entries are stored pushes nothing and enters hold mode, with all entries inside the boundary.
- R9: In hold mode, calls and branches have no effect. A return whose target equals call PC + RET_OFS of a function entry below the boundary cuts the stack back to that entry (the highest such entry is used) and leaves hold mode. Any other return is ignored.
- R10: ivl_start marks every stored entry stable before the same cycle's event is applied. Entries pushed afterwards start unstable.
- R11: One cycle after ivl_end, sig_valid pulses for exactly one cycle. sig_count is the number of consecutive stable entries counted from the bottom of the stack as it stood before that cycle's event. sig_hash starts at 0 and, for each of those entries from the bottom up, becomes rotl(h,5) ^ first ^ rotl(second,13).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Event present |
| ev_ready | output | 1 | Event accepted (always high) |
| ev_kind | input | 2 | 00 none, 01 call, 10 return, 11 taken branch |
| ev_pc | input | 32 | PC of the control-flow instruction |
| ev_target | input | 32 | Destination address |
| ivl_start | input | 1 | Interval start strobe |
| ivl_end | input | 1 | Interval end strobe |
| sig_valid | output | 1 | Signature valid pulse |
| sig_count | output | $clog2(DEPTH+1) | Stable entries in the signature |
| sig_hash | output | 32 | Address fold of the stable entries |
| stk_depth | output | $clog2(DEPTH+1) | Entries currently stored |
| hold_mode | output | 1 | Pushes suspended (recursion or overflow) |
| ret_err | output | 1 | Sticky flag for a return with no function entry |

## Verification
The assertions are checked on every cycle. They cover these properties:
- The depth never exceeds DEPTH and grows by at most one per event.
- A call in hold mode leaves the depth unchanged, and a return in hold mode never deepens the stack.
- The error flag stays set once raised.
- The signature pulse follows the end strobe exactly, and its count never exceeds the stack depth it was taken from.

Some behaviour can only be shown by the bench's scenarios, which compare against a reference model of the stack:
- whether the right entry is popped
- loop-iteration suppression
- which entry the recursion search picks
- the point at which the stack resynchronises
- the exact hash value

// File: rtl/ctxstk_pkg.sv
package ctxstk_pkg;

    localparam int ADDR_W = 32;

    typedef enum logic [1:0] {
        EV_NONE = 2'b00,
        EV_CALL = 2'b01,
        EV_RET  = 2'b10,
        EV_BR   = 2'b11
    } ev_kind_e;

    // first: call PC or loop start; second: callee or loop end
    typedef struct packed {
        logic [ADDR_W-1:0] first;
        logic [ADDR_W-1:0] second;
        logic              is_loop;
        logic              stable;
        logic              recur;
    } ent_t;

    function automatic logic [31:0] rotl32(input logic [31:0] v, input int s);
        return (v << s) | (v >> (32 - s));
    endfunction

    function automatic logic [31:0] fold_step(input logic [31:0] h,
                                              input logic [ADDR_W-1:0] f,
                                              input logic [ADDR_W-1:0] s);
        return rotl32(h, 5) ^ f ^ rotl32(s, 13);
    endfunction

endpackage

// File: rtl/ctx_stack_core.sv
module ctx_stack_core
    import ctxstk_pkg::*;
#(
    parameter int DEPTH   = 32,
    parameter int RET_OFS = 4,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  ev_kind_e          ev_kind,
    input  logic [ADDR_W-1:0] ev_pc,
    input  logic [ADDR_W-1:0] ev_target,
    input  logic              ivl_start,
    output ent_t              ents [DEPTH],
    output logic [CW-1:0]     count,
    output logic              hold,
    output logic              ret_err
);

    ent_t          ents_q [DEPTH];
    ent_t          ents_d [DEPTH];
    logic [CW-1:0] cnt_q, cnt_d, bnd_q, bnd_d;
    logic          hold_q, hold_d, err_q, err_d;

    ent_t top_e;
    logic top_loop;
    logic rec_hit, fn_hit, rs_hit;
    int   rec_idx, fn_idx, rs_idx;

    // associative searches across the occupied entries
    always_comb begin
        top_e   = '0;
        rec_hit = 1'b0; rec_idx = 0;
        fn_hit  = 1'b0; fn_idx  = 0;
        rs_hit  = 1'b0; rs_idx  = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (i == int'(cnt_q) - 1) top_e = ents_q[i];
            if (i < int'(cnt_q) && !ents_q[i].is_loop) begin
                fn_hit = 1'b1; fn_idx = i;
                if (i < int'(bnd_q) &&
                    ents_q[i].first + ADDR_W'(RET_OFS) == ev_target) begin
                    rs_hit = 1'b1; rs_idx = i;
                end
            end
        end
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (i < int'(cnt_q) && !ents_q[i].is_loop && ents_q[i].second == ev_target) begin
                rec_hit = 1'b1; rec_idx = i;
            end
        end
        top_loop = (cnt_q != '0) && top_e.is_loop;
    end

    logic exiting, backward, iterating;
    int   base;
    assign exiting   = top_loop && (ev_target < top_e.first || ev_target > top_e.second);
    assign backward  = ev_target < ev_pc;
    assign iterating = top_loop && !exiting && top_e.first == ev_target && top_e.second == ev_pc;
    assign base      = exiting ? int'(cnt_q) - 1 : int'(cnt_q);

    always_comb begin
        ents_d = ents_q;
        cnt_d  = cnt_q;
        bnd_d  = bnd_q;
        hold_d = hold_q;
        err_d  = err_q;
        if (ivl_start)
            for (int i = 0; i < DEPTH; i++)
                if (i < int'(cnt_q)) ents_d[i].stable = 1'b1;
        if (ev_valid) begin
            if (hold_q) begin
                if (ev_kind == EV_RET && rs_hit) begin
                    cnt_d  = CW'(rs_idx + 1);
                    hold_d = 1'b0;
                    for (int i = 0; i < DEPTH; i++) ents_d[i].recur = 1'b0;
                end
            end else begin
                unique case (ev_kind)
                    EV_CALL: begin
                        if (rec_hit) begin
                            for (int i = 0; i < DEPTH; i++)
                                if (i == rec_idx) ents_d[i].recur = 1'b1;
                            hold_d = 1'b1;
                            bnd_d  = CW'(rec_idx);
                        end else if (int'(cnt_q) == DEPTH) begin
                            hold_d = 1'b1;
                            bnd_d  = CW'(DEPTH);
                        end else begin
                            for (int i = 0; i < DEPTH; i++)
                                if (i == int'(cnt_q))
                                    ents_d[i] = '{first: ev_pc, second: ev_target,
                                                  is_loop: 1'b0, stable: 1'b0, recur: 1'b0};
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                    EV_RET: begin
                        if (fn_hit) cnt_d = CW'(fn_idx);
                        else begin
                            cnt_d = '0;
                            err_d = 1'b1;
                        end
                    end
                    EV_BR: begin
                        cnt_d = CW'(base);
                        if (backward && !iterating) begin
                            if (base == DEPTH) begin
                                hold_d = 1'b1;
                                bnd_d  = CW'(DEPTH);
                            end else begin
                                for (int i = 0; i < DEPTH; i++)
                                    if (i == base)
                                        ents_d[i] = '{first: ev_target, second: ev_pc,
                                                      is_loop: 1'b1, stable: 1'b0, recur: 1'b0};
                                cnt_d = CW'(base + 1);
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ents_q[i] <= '0;
            cnt_q  <= '0;
            bnd_q  <= '0;
            hold_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            ents_q <= ents_d;
            cnt_q  <= cnt_d;
            bnd_q  <= bnd_d;
            hold_q <= hold_d;
            err_q  <= err_d;
        end
    end

    assign ents    = ents_q;
    assign count   = cnt_q;
    assign hold    = hold_q;
    assign ret_err = err_q;

    assert_depth_bound_R8: assert property (@(posedge clk) disable iff (rst)
        int'(count) <= DEPTH);
    assert_push_step_R2: assert property (@(posedge clk) disable iff (rst)
        ev_valid |=> int'(count) <= int'($past(count)) + 1);
    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        ret_err |=> ret_err);
    assert_hold_call_R9: assert property (@(posedge clk) disable iff (rst)
        (hold && ev_valid && ev_kind == EV_CALL) |=> $stable(count));
    assert_hold_ret_R9: assert property (@(posedge clk) disable iff (rst)
        (hold && ev_valid && ev_kind == EV_RET) |=> int'(count) <= int'($past(count)));

endmodule

// File: rtl/ctx_sig_fold.sv
module ctx_sig_fold
    import ctxstk_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  ent_t          ents [DEPTH],
    input  logic [CW-1:0] count,
    input  logic          ivl_end,
    output logic          sig_valid,
    output logic [CW-1:0] sig_count,
    output logic [31:0]   sig_hash
);

    logic [CW-1:0] run_n;
    logic [31:0]   run_h;

    always_comb begin
        logic run;
        run   = 1'b1;
        run_n = '0;
        run_h = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (run && i < int'(count) && ents[i].stable) begin
                run_n = run_n + 1'b1;
                run_h = fold_step(run_h, ents[i].first, ents[i].second);
            end else begin
                run = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sig_valid <= 1'b0;
            sig_count <= '0;
            sig_hash  <= '0;
        end else begin
            sig_valid <= ivl_end;
            if (ivl_end) begin
                sig_count <= run_n;
                sig_hash  <= run_h;
            end
        end
    end

    assert_sig_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        sig_valid |-> $past(ivl_end));
    assert_sig_bound_R11: assert property (@(posedge clk) disable iff (rst)
        sig_valid |-> int'(sig_count) <= int'($past(count)));

endmodule

// File: rtl/ctx_stack_tracker.sv
module ctx_stack_tracker
    import ctxstk_pkg::*;
#(
    parameter int DEPTH   = 32,
    parameter int RET_OFS = 4,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ev_valid,
    output logic          ev_ready,
    input  logic [1:0]    ev_kind,
    input  logic [31:0]   ev_pc,
    input  logic [31:0]   ev_target,
    input  logic          ivl_start,
    input  logic          ivl_end,
    output logic          sig_valid,
    output logic [CW-1:0] sig_count,
    output logic [31:0]   sig_hash,
    output logic [CW-1:0] stk_depth,
    output logic          hold_mode,
    output logic          ret_err
);

    ent_t     ents [DEPTH];
    ev_kind_e kind;

    assign kind     = ev_kind_e'(ev_kind);
    assign ev_ready = 1'b1;

    ctx_stack_core #(.DEPTH(DEPTH), .RET_OFS(RET_OFS)) u_core (
        .clk      (clk),
        .rst      (rst),
        .ev_valid (ev_valid),
        .ev_kind  (kind),
        .ev_pc    (ev_pc),
        .ev_target(ev_target),
        .ivl_start(ivl_start),
        .ents     (ents),
        .count    (stk_depth),
        .hold     (hold_mode),
        .ret_err  (ret_err)
    );

    ctx_sig_fold #(.DEPTH(DEPTH)) u_fold (
        .clk      (clk),
        .rst      (rst),
        .ents     (ents),
        .count    (stk_depth),
        .ivl_end  (ivl_end),
        .sig_valid(sig_valid),
        .sig_count(sig_count),
        .sig_hash (sig_hash)
    );

endmodule

// File: tb/tb_ctx_stack_tracker.sv
`timescale 1ns/1ps
module tb_ctx_stack_tracker;

    localparam int D  = 32;
    localparam int RO = 4;
    localparam int CW = $clog2(D + 1);

    logic clk = 0, rst = 1;
    logic ev_valid = 0, ivl_start = 0, ivl_end = 0;
    logic [1:0] ev_kind = 0;
    logic [31:0] ev_pc = 0, ev_target = 0;
    logic ev_ready, sig_valid, hold_mode, ret_err;
    logic [CW-1:0] sig_count, stk_depth;
    logic [31:0] sig_hash;

    always #10 clk = ~clk;

    ctx_stack_tracker dut (.*);

    int total = 0, bad = 0;
    bit done = 0;

    // reference model
    logic [31:0] m_f [D], m_s [D];
    bit m_loop [D], m_st [D];
    int m_cnt = 0, m_bnd = 0;
    bit m_hold = 0, m_err = 0;

    function automatic logic [31:0] rl(logic [31:0] v, int s);
        return (v << s) | (v >> (32 - s));
    endfunction

    task automatic chk(string tag, string what, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model(logic [1:0] k, logic [31:0] pc, logic [31:0] tg, bit s);
        int ri = -1, fi = -1, si = -1, base;
        bit tl, ex;
        if (s) for (int i = 0; i < m_cnt; i++) m_st[i] = 1;
        for (int i = 0; i < m_cnt; i++) if (!m_loop[i]) begin
            fi = i;
            if (i < m_bnd && m_f[i] + RO == tg) si = i;
        end
        for (int i = m_cnt - 1; i >= 0; i--) if (!m_loop[i] && m_s[i] == tg) ri = i;
        if (m_hold) begin
            if (k == 2'b10 && si >= 0) begin m_cnt = si + 1; m_hold = 0; end
            return;
        end
        case (k)
            2'b01: if (ri >= 0) begin m_hold = 1; m_bnd = ri; end
                   else if (m_cnt == D) begin m_hold = 1; m_bnd = D; end
                   else begin m_f[m_cnt] = pc; m_s[m_cnt] = tg; m_loop[m_cnt] = 0; m_st[m_cnt] = 0; m_cnt++; end
            2'b10: if (fi >= 0) m_cnt = fi; else begin m_cnt = 0; m_err = 1; end
            2'b11: begin
                tl = m_cnt > 0 && m_loop[m_cnt-1];
                ex = tl && (tg < m_f[m_cnt-1] || tg > m_s[m_cnt-1]);
                base = ex ? m_cnt - 1 : m_cnt;
                m_cnt = base;
                if (tg < pc && !(tl && !ex && m_f[base-1] == tg && m_s[base-1] == pc)) begin
                    if (base == D) begin m_hold = 1; m_bnd = D; end
                    else begin m_f[base] = tg; m_s[base] = pc; m_loop[base] = 1; m_st[base] = 0; m_cnt = base + 1; end
                end
            end
            default: ;
        endcase
    endtask

    task automatic step(logic [1:0] k, logic [31:0] pc, logic [31:0] tg,
                        bit s, bit e, string tag);
        int en = 0;
        logic [31:0] eh = 0;
        @(negedge clk);
        ev_valid = 1; ev_kind = k; ev_pc = pc; ev_target = tg;
        ivl_start = s; ivl_end = e;
        for (int i = 0; i < m_cnt; i++) begin
            if (!m_st[i]) break;
            en++;
            eh = rl(eh, 5) ^ m_f[i] ^ rl(m_s[i], 13);
        end
        model(k, pc, tg, s);
        @(negedge clk);
        ev_valid = 0; ev_kind = 0; ivl_start = 0; ivl_end = 0;
        chk(tag, "depth", stk_depth, m_cnt);
        chk(tag, "hold", hold_mode, m_hold);
        chk(tag, "err", ret_err, m_err);
        chk(e ? "R11" : tag, "sig_valid", sig_valid, e);
        if (e) begin
            chk("R11", "sig_count", sig_count, en);
            chk("R11", "sig_hash", sig_hash, eh);
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed = 32'h5eed_1234;
        int r, k;
        logic [31:0] pc, tg;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "depth", stk_depth, 0);
        chk("R1", "hold", hold_mode, 0);
        chk("R1", "err", ret_err, 0);
        chk("R1", "sig_valid", sig_valid, 0);
        chk("R1", "ready", ev_ready, 1);
        step(2'b00, 32'h10, 32'h4, 0, 0, "R1");
        // R2 pushes
        step(2'b01, 32'h100, 32'h1000, 0, 0, "R2");
        step(2'b01, 32'h1010, 32'h2000, 0, 0, "R2");
        // R4 loop push and iteration
        step(2'b11, 32'h2040, 32'h2020, 0, 0, "R4");
        step(2'b11, 32'h2040, 32'h2020, 0, 0, "R4");
        // R5 exit forward, then backward exit replacing slot
        step(2'b11, 32'h2050, 32'h2060, 0, 0, "R5");
        step(2'b11, 32'h2040, 32'h2020, 0, 0, "R5");
        step(2'b11, 32'h2090, 32'h2010, 0, 0, "R5");
        // R3 return pops loop plus function
        step(2'b10, 32'h20a0, 32'h1014, 0, 0, "R3");
        // R10 / R11 stable marking and signature
        step(2'b00, 0, 0, 1, 0, "R10");
        step(2'b01, 32'h1020, 32'h3000, 0, 0, "R10");
        step(2'b00, 0, 0, 0, 1, "R11");
        step(2'b01, 32'h3010, 32'h4000, 1, 1, "R11");
        // R7 recursion, R9 ignored events and resync
        step(2'b01, 32'h4010, 32'h3000, 0, 0, "R7");
        step(2'b01, 32'h4020, 32'h5000, 0, 0, "R9");
        step(2'b11, 32'h4040, 32'h4030, 0, 0, "R9");
        step(2'b10, 32'h4050, 32'h9999, 0, 0, "R9");
        step(2'b10, 32'h4060, 32'h104, 0, 0, "R9");
        // R6 empty return
        step(2'b10, 32'h1100, 32'h0, 0, 0, "R6");
        step(2'b10, 32'h1100, 32'h0, 0, 0, "R6");
        // R8 overflow
        for (int i = 0; i < D; i++) step(2'b01, 32'h8000 + i * 16, 32'h10000 + i * 256, 0, 0, "R8");
        step(2'b01, 32'hf000, 32'hf0000, 0, 0, "R8");
        step(2'b11, 32'hf100, 32'hf000, 0, 0, "R8");
        step(2'b10, 32'hf200, 32'h8000 + 10 * 16 + RO, 0, 0, "R9");
        // random phase
        for (int n = 0; n < 4000; n++) begin
            r = $urandom_range(0, 99);
            k = r < 35 ? 1 : (r < 60 ? 2 : 3);
            pc = 32'h100 * $urandom_range(1, 40) + 4 * $urandom_range(0, 15);
            if (k == 1) tg = 32'h20000 + 32'h100 * $urandom_range(0, 23);
            else if (k == 2) begin
                if (m_cnt > 0 && $urandom_range(0, 1) == 1)
                    tg = m_f[$urandom_range(0, m_cnt - 1)] + RO;
                else tg = pc + 4;
            end else tg = $urandom_range(0, 1) ? pc - 4 * $urandom_range(1, 8) : pc + 4 * $urandom_range(1, 8);
            step(k[1:0], pc, tg, $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0,
                 k == 1 ? "R2" : (k == 2 ? "R3" : "R4"));
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule